// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block collects a parameterised set of level-sensitive interrupt lines and folds them onto a handful of output interrupt lines, one output for each block of 64 inputs. Software controls it through a small synchronous register port. Through that port it enables each input with a mask bit and can raise any input artificially with a set bit. It can read the masked status of every input, pick a steering channel, disable each output on its own, and see which output groups are pending before that per-output gating.

All per-input registers are 32-bit words. The word order is reversed: the lowest-addressed word of each bank holds the highest-numbered inputs. The mask, set and status banks sit back to back after the channel register, so their stride depends on the word count N = NUM_IN / 32. Each output is registered, so an output follows its group one clock late and drops one clock after the group goes quiet.

Top module: `irq_steer_agg`

## Requirements
- R1: After reset the channel, mask, set and master-disable registers all read zero, and every bit of `irq_out` is low even when inputs are active.
- R2: The channel register at byte address 0x0 is read/write. It keeps CHAN_W bits and its upper read bits are zero. While it holds zero every output is low.
- R3: Mask word n sits at address 4+4n and is read/write. A mask bit of 1 enables its input and a 0 blocks that input from status and from the outputs.
- R4: Set word n sits at address 4N+4+4n and is read/write. A set bit acts as an active input level until software clears it.
- R5: Input i appears at bit (i mod 32) of word N-1-(i div 32). Status word n at 8N+4+4n reads (input OR set) AND mask. Writes to status words change nothing.
- R6: Output k goes high on the clock edge after its group's status OR goes high. It stays high while the group stays active and drops on the edge after the group goes quiet.
- R7: Output k covers inputs 64k to 64k+63. When NUM_IN is not a multiple of 64, the last output covers only the last 32 inputs.
- R8: The master-disable register at 12N+4 is read/write. A 1 in bit k holds output k low.
- R9: The master-status register at 12N+8 is read-only. Its bit k is the OR of group k's status bits, ungated by channel or master disable.
- R10: Reads from unmapped or unaligned addresses return zero. Writes to them change no register.
- R11: Read data is registered: `reg_rdata` shows the register addressed at one clock edge from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Level-sensitive interrupt inputs |
| reg_addr | input | ADDR_W | Byte address of register access |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | (NUM_IN+63)/64 | Aggregated output interrupts |

## Verification
A corrupted mask, set or disable register shows up within one clock at `irq_out`. It is also visible one clock after a read of that register, or of the status word that depends on it. A wrong word order or a wrong group boundary fires the wrong output bit for an input at the edge of a group: inputs 63, 64, 127, 128 and the last input show it at once. A missing or extra output register shows up as an output that changes one cycle early or late relative to the input edge.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  typedef logic [31:0] word_t;

  function automatic int mask_off(int nw, int n);
    return 4 + 4 * n;
  endfunction

  function automatic int set_off(int nw, int n);
    return 4 * nw + 4 + 4 * n;
  endfunction

  function automatic int stat_off(int nw, int n);
    return 8 * nw + 4 + 4 * n;
  endfunction

  function automatic int mdis_off(int nw);
    return 12 * nw + 4;
  endfunction

  function automatic int mstat_off(int nw);
    return 12 * nw + 8;
  endfunction
endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs #(
  parameter int NW     = 5,
  parameter int NOUT   = 3,
  parameter int CHAN_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_we,
  input  logic [31:0]           reg_wdata,
  input  logic [NW-1:0][31:0]   stat_w,
  input  logic [NOUT-1:0]       grp_or,
  output logic [31:0]           reg_rdata,
  output logic [NW-1:0][31:0]   mask_q,
  output logic [NW-1:0][31:0]   set_q,
  output logic [CHAN_W-1:0]     chan_q,
  output logic [NOUT-1:0]       mdis_q
);
  import irq_steer_pkg::*;

  localparam logic [ADDR_W-1:0] MDIS_A  = ADDR_W'(mdis_off(NW));
  localparam logic [ADDR_W-1:0] MSTAT_A = ADDR_W'(mstat_off(NW));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      set_q  <= '0;
      chan_q <= '0;
      mdis_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == '0) chan_q <= reg_wdata[CHAN_W-1:0];
      if (reg_addr == MDIS_A) mdis_q <= reg_wdata[NOUT-1:0];
      for (int n = 0; n < NW; n++) begin
        if (reg_addr == ADDR_W'(mask_off(NW, n))) mask_q[n] <= reg_wdata;
        if (reg_addr == ADDR_W'(set_off(NW, n)))  set_q[n]  <= reg_wdata;
      end
    end
  end

  logic [31:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (reg_addr == '0)      rd_d = 32'(chan_q);
    if (reg_addr == MDIS_A)  rd_d = 32'(mdis_q);
    if (reg_addr == MSTAT_A) rd_d = 32'(grp_or);
    for (int n = 0; n < NW; n++) begin
      if (reg_addr == ADDR_W'(mask_off(NW, n))) rd_d = mask_q[n];
      if (reg_addr == ADDR_W'(set_off(NW, n)))  rd_d = set_q[n];
      if (reg_addr == ADDR_W'(stat_off(NW, n))) rd_d = stat_w[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end
endmodule

// File: rtl/irq_steer_status.sv
module irq_steer_status #(
  parameter int NUM_IN = 160,
  parameter int NW     = NUM_IN / 32
) (
  input  logic [NUM_IN-1:0]     irq_in,
  input  logic [NW-1:0][31:0]   mask_q,
  input  logic [NW-1:0][31:0]   set_q,
  output logic [NW-1:0][31:0]   stat_w
);
  // word w carries inputs 32*(NW-1-w) .. 32*(NW-1-w)+31
  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam int BASE = 32 * (NW - 1 - w);
    assign stat_w[w] = (irq_in[BASE +: 32] | set_q[w]) & mask_q[w];
  end
endmodule

// File: rtl/irq_steer_group.sv
module irq_steer_group #(
  parameter int NW     = 5,
  parameter int NOUT   = 3,
  parameter int CHAN_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NW-1:0][31:0] stat_w,
  input  logic [CHAN_W-1:0]   chan_q,
  input  logic [NOUT-1:0]     mdis_q,
  output logic [NOUT-1:0]     grp_or,
  output logic [NOUT-1:0]     irq_out
);
  for (genvar k = 0; k < NOUT; k++) begin : g_grp
    localparam int LO = NW - 1 - 2 * k;
    if (2 * k + 1 < NW) begin : g_pair
      assign grp_or[k] = (|stat_w[LO]) | (|stat_w[LO-1]);
    end else begin : g_single
      assign grp_or[k] = |stat_w[LO];
    end
  end

  logic chan_on;
  assign chan_on = |chan_q;

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= grp_or & ~mdis_q & {NOUT{chan_on}};
  end
endmodule

// File: rtl/irq_steer_agg.sv
module irq_steer_agg #(
  parameter int NUM_IN = 160,
  parameter int CHAN_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_IN-1:0]           irq_in,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_we,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic [(NUM_IN+63)/64-1:0]   irq_out
);
  localparam int NW   = NUM_IN / 32;
  localparam int NOUT = (NUM_IN + 63) / 64;

  logic [NW-1:0][31:0] mask_q, set_q, stat_w;
  logic [CHAN_W-1:0]   chan_q;
  logic [NOUT-1:0]     mdis_q, grp_or;

  irq_steer_regs #(.NW(NW), .NOUT(NOUT), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .stat_w(stat_w), .grp_or(grp_or),
    .reg_rdata(reg_rdata), .mask_q(mask_q), .set_q(set_q),
    .chan_q(chan_q), .mdis_q(mdis_q)
  );

  irq_steer_status #(.NUM_IN(NUM_IN), .NW(NW)) u_stat (
    .irq_in(irq_in), .mask_q(mask_q), .set_q(set_q), .stat_w(stat_w)
  );

  irq_steer_group #(.NW(NW), .NOUT(NOUT), .CHAN_W(CHAN_W)) u_grp (
    .clk(clk), .rst(rst), .stat_w(stat_w), .chan_q(chan_q),
    .mdis_q(mdis_q), .grp_or(grp_or), .irq_out(irq_out)
  );
endmodule

// File: rtl/irq_steer_agg_chk.sv
module irq_steer_agg_chk #(
  parameter int NUM_IN = 160,
  parameter int CHAN_W = 8,
  parameter int ADDR_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [31:0]               reg_rdata,
  input logic [(NUM_IN+63)/64-1:0] irq_out,
  input logic [(NUM_IN+63)/64-1:0] grp_or,
  input logic [(NUM_IN+63)/64-1:0] mdis_q,
  input logic [CHAN_W-1:0]         chan_q
);
  localparam int NW = NUM_IN / 32;
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(12 * NW + 8);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> irq_out == '0);

  p_chan_gate_r2: assert property (@(posedge clk) disable iff (rst)
    chan_q == '0 |=> irq_out == '0);

  p_needs_group_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_out & ~$past(grp_or)) == '0);

  p_mdis_gate_r8: assert property (@(posedge clk) disable iff (rst)
    mdis_q != '0 |=> (irq_out & $past(mdis_q)) == '0);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_addr > LAST_A || reg_addr[1:0] != 2'b00) |=> reg_rdata == '0);
endmodule

bind irq_steer_agg irq_steer_agg_chk #(.NUM_IN(NUM_IN), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .irq_out(irq_out), .grp_or(grp_or), .mdis_q(mdis_q), .chan_q(chan_q)
);

// File: tb/irq_steer_agg_test.sv
`timescale 1ns/1ps
module irq_steer_agg_test;
  localparam int NUM_IN = 160;
  localparam int NW     = NUM_IN / 32;
  localparam int NOUT   = (NUM_IN + 63) / 64;

  logic clk = 0, rst = 1, reg_we = 0;
  logic [NUM_IN-1:0] irq_in = '0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NOUT-1:0] irq_out;
  int checks = 0, failures = 0;

  irq_steer_agg #(.NUM_IN(NUM_IN), .CHAN_W(8), .ADDR_W(8)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] a_mask(int n); return 8'(4 + 4 * n); endfunction
  function automatic logic [7:0] a_set(int n);  return 8'(4 * NW + 4 + 4 * n); endfunction
  function automatic logic [7:0] a_stat(int n); return 8'(8 * NW + 4 + 4 * n); endfunction
  localparam logic [7:0] A_MDIS  = 8'(12 * NW + 4);
  localparam logic [7:0] A_MSTAT = 8'(12 * NW + 8);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_we = 1; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_we = 0;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic step; @(negedge clk); endtask

  task automatic drive_one(int i);
    @(negedge clk); irq_in = '0; irq_in[i] = 1'b1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 out during reset", 32'(irq_out), 0);
    rst = 0; step; step;
    chk("R1 out after reset", 32'(irq_out), 0);
    rd(8'h00, d);      chk("R1 chan", d, 0);
    rd(a_mask(0), d);  chk("R1 mask0", d, 0);
    rd(a_set(2), d);   chk("R1 set2", d, 0);
    rd(A_MDIS, d);     chk("R1 mdis", d, 0);
    rd(a_stat(0), d);  chk("R1 status masked", d, 0);
    @(negedge clk); irq_in = '0;
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FF04); rd(8'h00, d); chk("R2 chan width", d, 32'h04);
    for (int n = 0; n < NW; n++) wr(a_mask(n), 32'hA5A5_0000 + 32'(n));
    for (int n = 0; n < NW; n++) begin
      rd(a_mask(n), d); chk("R3 mask readback", d, 32'hA5A5_0000 + 32'(n));
    end
    wr(a_set(3), 32'h0000_0000); rd(a_set(3), d); chk("R4 set readback", d, 0);
    for (int n = 0; n < NW; n++) wr(a_mask(n), 32'hFFFF_FFFF);
  endtask

  task automatic t_timing;
    drive_one(70);
    #1 chk("R6 not early", 32'(irq_out), 0);
    step; chk("R6 asserted", 32'(irq_out), 32'b010);
    @(negedge clk); irq_in = '0;
    #1 chk("R6 held until edge", 32'(irq_out), 32'b010);
    step; chk("R6 level drop", 32'(irq_out), 0);
  endtask

  task automatic t_groups;
    int pts[6] = '{0, 63, 64, 127, 128, 159};
    foreach (pts[j]) begin
      drive_one(pts[j]); step;
      chk($sformatf("R7 input %0d", pts[j]), 32'(irq_out), 32'(1) << (pts[j] / 64));
    end
    @(negedge clk); irq_in = '0; step;
  endtask

  task automatic t_status;
    logic [31:0] d;
    drive_one(5);   rd(a_stat(4), d); chk("R5 input 5 -> word 4", d, 32'h20);
    drive_one(150); rd(a_stat(0), d); chk("R5 input 150 -> word 0", d, 32'h0040_0000);
    wr(a_stat(0), 32'h0); rd(a_stat(0), d); chk("R5 status write ignored", d, 32'h0040_0000);
    wr(a_mask(0), 32'hFFBF_FFFF); rd(a_stat(0), d); chk("R3 masked status", d, 0);
    chk("R3 masked output", 32'(irq_out), 0);
    wr(a_mask(0), 32'hFFFF_FFFF);
    @(negedge clk); irq_in = '0; step;
  endtask

  task automatic t_set;
    logic [31:0] d;
    wr(a_set(1), 32'h10); step;
    chk("R4 set drives out1", 32'(irq_out), 32'b010);
    rd(a_stat(1), d); chk("R4 set in status", d, 32'h10);
    wr(a_set(1), 32'h0); step;
    chk("R4 set cleared", 32'(irq_out), 0);
  endtask

  task automatic t_master;
    logic [31:0] d;
    drive_one(64); step;
    wr(A_MDIS, 32'h2); step;
    chk("R8 disabled out1", 32'(irq_out), 0);
    rd(A_MDIS, d);  chk("R8 mdis readback", d, 32'h2);
    rd(A_MSTAT, d); chk("R9 ungated by mdis", d, 32'h2);
    wr(A_MDIS, 32'h0); step;
    chk("R8 re-enabled", 32'(irq_out), 32'b010);
    wr(8'h00, 32'h0); step;
    chk("R2 zero channel blocks", 32'(irq_out), 0);
    rd(A_MSTAT, d); chk("R9 ungated by chan", d, 32'h2);
    wr(8'h00, 32'h1);
    @(negedge clk); irq_in = '0; step;
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(A_MSTAT + 8'd4, d); chk("R10 above map", d, 0);
    rd(8'h06, d);          chk("R10 unaligned", d, 0);
    wr(A_MSTAT + 8'd4, 32'hFFFF_FFFF);
    wr(8'h05, 32'h0);
    rd(A_MDIS, d);     chk("R10 write no effect mdis", d, 0);
    rd(a_mask(0), d);  chk("R10 write no effect mask", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    rd(a_mask(1), d);
    @(negedge clk); reg_addr = 8'h00;
    #1 chk("R11 old data before edge", reg_rdata, 32'hFFFF_FFFF);
    step; chk("R11 new data after edge", reg_rdata, 32'h1);
  endtask

  initial begin
    irq_in = '1;
    repeat (3) @(negedge clk);
    t_reset;
    t_regs;
    t_timing;
    t_groups;
    t_status;
    t_set;
    wr(8'h00, 32'h1);
    t_master;
    t_unmapped;
    t_latency;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule